// File: doc/BRIEF.md
# Symbol-to-MLT-3 Transmit Encoder

This block turns a stream of pre-scrambled 5-bit line symbols into a three-level MLT-3 line code for an external line driver. It runs from one bit-rate clock. Inside, a divide-by-`SYM_BITS` counter makes the symbol-rate enable, and the block raises `symSample` for the cycle whose closing clock edge captures `symIn`. The upstream logic presents each symbol before that edge. The captured symbol is shifted out one bit per clock. The serial NRZ stream is converted to NRZI, and each NRZI transition moves the line level one step around the MLT-3 cycle.

The line level is a 2-bit signed value. The transmitter runs only while the speed-select input is high and the active-low power-down input is high. If either one drops, the line is forced to zero in the same cycle, and every internal stage is cleared at the next edge. A registered copy of the serial NRZ bit is brought out so that a receive block can use it for loopback.

Top module: `mlt3_tx_encoder`

## Requirements
- R1: While running, `symSample` is high for exactly one cycle in every `SYM_BITS` (5) cycles. The symbol on `symIn` is captured at the rising edge that ends a cycle with `symSample` high.
- R2: After the capture edge, `nrzTap` presents the symbol's bits one per clock, starting right after that edge. With `MSB_FIRST=1` the order is bit 4 down to bit 0. With `MSB_FIRST=0` it is bit 0 up to bit 4.
- R3: An NRZ 1 toggles the internal NRZI state, and an NRZ 0 holds it. The line level therefore changes for each 1 bit and holds for each 0 bit.
- R4: Each change steps the level through the repeating cycle 0, +1, 0, -1. `lineLevel` encodes +1 as 2'b01, 0 as 2'b00 and -1 as 2'b11, and never shows 2'b10.
- R5: The line level that reflects a bit appears two clocks after that bit appears on `nrzTap`. For the first bit of a symbol, this is two bit times after the capture edge, which is within the 10.5 bit-time budget.
- R6: While `speedSel` is low, `lineLevel` is 2'b00 in the same cycle. The serializer, NRZI and MLT-3 state are cleared, so after re-enabling, the first 1 bit moves the line to +1.
- R7: While `pwrOnN` is low, the behaviour is the same as in R6.
- R8: After reset, `lineLevel` is 2'b00 and `nrzTap` is 0, and the first level step goes to +1.
- R9: After a disabled period, `symSample` is high in the first running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Active-low asynchronous reset |
| symIn | input | SYM_BITS | Symbol to transmit, captured at the edge after `symSample` |
| speedSel | input | 1 | High enables transmission; low disables it and clears the state |
| pwrOnN | input | 1 | Low powers the block down and clears the state |
| symSample | output | 1 | High in the cycle whose closing edge captures `symIn` |
| nrzTap | output | 1 | Registered serial NRZ bit, for loopback |
| lineLevel | output | 2 | MLT-3 level: 01 = +1, 00 = 0, 11 = -1 |

## Verification
The bench builds two copies of the encoder that share the same stimulus. `u0` uses the defaults (`SYM_BITS=5`, MSB first), and `u1` sets `MSB_FIRST=0`, so both serializer variants are checked bit by bit against the same symbol queue. A cycle-level model written from R2 to R4 follows every symbol, including all-ones, all-zeros and alternating patterns. This model covers every level step and the two-clock lag. Directed scenarios drop `speedSel` or `pwrOnN` in the middle of a symbol, leaving the MLT-3 direction negative, to show that re-enabling restarts at phase zero and steps to +1.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;

  // Signed two-bit line levels
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } line_lvl_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;   // transmitter active
    logic load;  // capture a symbol at this edge
  } tx_strobe_t;

endpackage

// File: rtl/mlt3_tx_ctrl.sv
module mlt3_tx_ctrl
  import mlt3_pkg::*;
#(
  parameter int SYM_BITS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       speedSel,
  input  logic       pwrOnN,
  output tx_strobe_t strobe
);

  localparam int PH_W = (SYM_BITS > 1) ? $clog2(SYM_BITS) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SYM_BITS - 1);

  logic [PH_W-1:0] phase;
  logic            runNow;

  assign runNow = speedSel & pwrOnN;

  // Divide-by-SYM_BITS phase counter, held at zero while stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (!runNow) begin
      phase <= '0;
    end else if (phase == LAST_PH) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strobe.run  = runNow;
    strobe.load = runNow && (phase == '0);
  end

  // R1: a capture is never followed directly by another capture
  a_r1_single_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !strobe.load);

  // R9: a stopped cycle leaves the counter at phase zero
  a_r9_phase_clear: assert property (@(posedge clk) disable iff (!rstN)
    !runNow |=> (phase == '0));

  // R1: the phase never leaves its range
  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rstN)
    phase <= LAST_PH);

endmodule

// File: rtl/mlt3_tx_datapath.sv
module mlt3_tx_datapath
  import mlt3_pkg::*;
#(
  parameter int SYM_BITS  = 5,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  tx_strobe_t          strobe,
  input  logic [SYM_BITS-1:0] symIn,
  output logic                nrzTap,
  output logic [1:0]          lineLevel
);

  logic [SYM_BITS-1:0] shiftReg;
  logic [SYM_BITS-1:0] shiftNext;
  logic                firstBit;
  logic                nextBit;
  logic                nrzReg;
  logic                nrziReg;
  logic                nrziPrev;
  line_lvl_t           lvlReg;
  line_lvl_t           lvlNext;
  logic                dirPos;
  logic                dirNext;

  // The parameter picks the bit order of the serializer
  generate
    if (MSB_FIRST) begin : g_msb
      assign firstBit  = symIn[SYM_BITS-1];
      assign nextBit   = shiftReg[SYM_BITS-1];
      assign shiftNext = strobe.load ? (symIn << 1) : (shiftReg << 1);
    end else begin : g_lsb
      assign firstBit  = symIn[0];
      assign nextBit   = shiftReg[0];
      assign shiftNext = strobe.load ? (symIn >> 1) : (shiftReg >> 1);
    end
  endgenerate

  // 5:1 serializer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      nrzReg   <= 1'b0;
    end else if (!strobe.run) begin
      shiftReg <= '0;
      nrzReg   <= 1'b0;
    end else begin
      shiftReg <= shiftNext;
      nrzReg   <= strobe.load ? firstBit : nextBit;
    end
  end

  // NRZ to NRZI: a one toggles the state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nrziReg  <= 1'b0;
      nrziPrev <= 1'b0;
    end else if (!strobe.run) begin
      nrziReg  <= 1'b0;
      nrziPrev <= 1'b0;
    end else begin
      nrziReg  <= nrziReg ^ nrzReg;
      nrziPrev <= nrziReg;
    end
  end

  // MLT-3 stepping: 0 -> +1 -> 0 -> -1 -> 0 on each NRZI edge
  always_comb begin
    lvlNext = lvlReg;
    dirNext = dirPos;
    if (nrziReg != nrziPrev) begin
      case (lvlReg)
        LVL_ZERO: lvlNext = dirPos ? LVL_POS : LVL_NEG;
        LVL_POS: begin
          lvlNext = LVL_ZERO;
          dirNext = 1'b0;
        end
        default: begin
          lvlNext = LVL_ZERO;
          dirNext = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlReg <= LVL_ZERO;
      dirPos <= 1'b1;
    end else if (!strobe.run) begin
      lvlReg <= LVL_ZERO;
      dirPos <= 1'b1;
    end else begin
      lvlReg <= lvlNext;
      dirPos <= dirNext;
    end
  end

  assign nrzTap    = nrzReg;
  assign lineLevel = strobe.run ? lvlReg : LVL_ZERO;

  // R6 / R7: a stopped cycle clears the serializer and MLT-3 state
  a_r6_clear_state: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (lvlReg == LVL_ZERO && !nrzReg && dirPos && !nrziReg));

  // R3: an NRZ zero leaves the NRZI state unchanged
  a_r3_nrzi_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !nrzReg) |=> (nrziReg == $past(nrziReg)));

  // R4: a nonzero level either holds or returns to zero
  a_r4_nonzero_exit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && lvlReg != LVL_ZERO) |=> (lvlReg == $past(lvlReg) || lvlReg == LVL_ZERO));

  // R4: the unused code never appears on the line
  a_r4_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    lineLevel != 2'b10);

endmodule

// File: rtl/mlt3_tx_encoder.sv
module mlt3_tx_encoder
  import mlt3_pkg::*;
#(
  parameter int SYM_BITS  = 5,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SYM_BITS-1:0] symIn,
  input  logic                speedSel,
  input  logic                pwrOnN,
  output logic                symSample,
  output logic                nrzTap,
  output logic [1:0]          lineLevel
);

  tx_strobe_t strobe;

  mlt3_tx_ctrl #(.SYM_BITS(SYM_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .speedSel (speedSel),
    .pwrOnN   (pwrOnN),
    .strobe   (strobe)
  );

  mlt3_tx_datapath #(.SYM_BITS(SYM_BITS), .MSB_FIRST(MSB_FIRST)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .symIn     (symIn),
    .nrzTap    (nrzTap),
    .lineLevel (lineLevel)
  );

  assign symSample = strobe.load;

endmodule

// File: tb/sim_mlt3_tx_encoder.sv
`timescale 1ns/1ps
module sim_mlt3_tx_encoder;

  localparam int CLK_PER = 8;
  localparam int NB      = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NB-1:0] symIn = '0;
  logic          speedSel = 1'b1;
  logic          pwrOnN = 1'b1;
  logic          symSample, nrzTap, symSample1, nrzTap1;
  logic [1:0]    lineLevel, lineLevel1;

  int nChecks = 0;
  int nFails  = 0;
  bit monOn   = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  mlt3_tx_encoder #(.SYM_BITS(NB), .MSB_FIRST(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .symIn(symIn), .speedSel(speedSel), .pwrOnN(pwrOnN),
    .symSample(symSample), .nrzTap(nrzTap), .lineLevel(lineLevel));

  mlt3_tx_encoder #(.SYM_BITS(NB), .MSB_FIRST(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .symIn(symIn), .speedSel(speedSel), .pwrOnN(pwrOnN),
    .symSample(symSample1), .nrzTap(nrzTap1), .lineLevel(lineLevel1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Signed level from the R4 encoding; 99 marks an illegal code
  function automatic int lvlVal(input logic [1:0] c);
    case (c)
      2'b01: return 1;
      2'b00: return 0;
      2'b11: return -1;
      default: return 99;
    endcase
  endfunction

  // ---------------- cycle-level model (R1..R4) ----------------
  int qa[0:15];
  int qaN = 0;
  int qb[0:15];
  int qbN = 0;
  int p1 = 0, p2 = 0;
  int mLvl = 0;
  int mDir = 1;
  int since = 0;
  bit haveLoad = 1'b0;

  always @(negedge clk) begin
    if (monOn) begin
      if (!(speedSel && pwrOnN)) begin
        chk(lineLevel == 2'b00, "R6/R7 forced zero", lvlVal(lineLevel), 0);
        qaN = 0; qbN = 0; p1 = 0; p2 = 0; mLvl = 0; mDir = 1;
        since = 0; haveLoad = 1'b0;
      end else begin
        int curA, curB;
        curA = (qaN > 0) ? qa[0] : 0;
        curB = (qbN > 0) ? qb[0] : 0;
        chk(nrzTap == curA[0], "R2 msb-first tap", nrzTap, curA);
        chk(nrzTap1 == curB[0], "R2 lsb-first tap", nrzTap1, curB);
        if (qaN > 0) begin
          for (int i = 0; i < 15; i++) qa[i] = qa[i+1];
          qaN--;
        end
        if (qbN > 0) begin
          for (int i = 0; i < 15; i++) qb[i] = qb[i+1];
          qbN--;
        end
        if (p2 != 0) begin
          if (mLvl == 0) mLvl = mDir;
          else begin
            mDir = -mLvl;
            mLvl = 0;
          end
        end
        chk(lvlVal(lineLevel) == mLvl, "R3/R4/R5 line level", lvlVal(lineLevel), mLvl);
        p2 = p1; p1 = curA;
        since++;
        if (symSample) begin
          if (haveLoad) chk(since == NB, "R1 capture spacing", since, NB);
          haveLoad = 1'b1;
          since = 0;
          for (int i = 0; i < NB; i++) begin
            qa[qaN] = symIn[NB-1-i]; qaN++;
            qb[qbN] = symIn[i];      qbN++;
          end
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic sendSym(input logic [NB-1:0] v);
    do begin
      @(posedge clk); #1;
    end while (!symSample);
    symIn = v;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    @(negedge clk);
    chk(lineLevel == 2'b00, "R8 reset line", lvlVal(lineLevel), 0);
    chk(nrzTap == 1'b0, "R8 reset tap", nrzTap, 0);
    rstN = 1'b1;
    monOn = 1'b1;
    sendSym(5'b10000);
    symIn = '0;
    idle(3);
    @(negedge clk);
    chk(lvlVal(lineLevel) == 1, "R8 first step positive", lvlVal(lineLevel), 1);
  endtask

  task automatic tPatterns();
    logic [NB-1:0] pats [0:7];
    pats[0] = 5'b11111; pats[1] = 5'b00000; pats[2] = 5'b10101; pats[3] = 5'b01010;
    pats[4] = 5'b00001; pats[5] = 5'b11000; pats[6] = 5'b01110; pats[7] = 5'b10011;
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 8; k++) sendSym(pats[k]);
    symIn = '0;
    idle(12);
  endtask

  task automatic tLatency();
    int n;
    speedSel = 1'b0; idle(3);
    speedSel = 1'b1;
    sendSym(5'b10000);
    symIn = '0;
    n = 0;
    @(negedge clk);
    while (lineLevel == 2'b00 && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk(n == 2, "R5 latency clocks", n, 2);
    chk(n <= 10, "R5 latency within budget", n, 10);
    idle(8);
  endtask

  // Leave direction negative, stop, restart: first step must be +1
  task automatic tStop(input bit usePwr);
    speedSel = 1'b0; idle(2); speedSel = 1'b1;
    sendSym(5'b11000);
    symIn = '0;
    idle(6);
    @(negedge clk);
    chk(lineLevel == 2'b00, usePwr ? "R7 pre-stop level" : "R6 pre-stop level", lvlVal(lineLevel), 0);
    sendSym(5'b00100);
    symIn = 5'b10000;
    @(posedge clk); #1;
    if (usePwr) pwrOnN = 1'b0; else speedSel = 1'b0;
    @(negedge clk);
    chk(lineLevel == 2'b00, usePwr ? "R7 immediate zero" : "R6 immediate zero", lvlVal(lineLevel), 0);
    idle(4);
    @(negedge clk);
    chk(lineLevel == 2'b00, usePwr ? "R7 held zero" : "R6 held zero", lvlVal(lineLevel), 0);
    @(posedge clk); #1;
    if (usePwr) pwrOnN = 1'b1; else speedSel = 1'b1;
    @(negedge clk);
    chk(symSample == 1'b1, "R9 capture in first running cycle", symSample, 1);
    @(posedge clk); #1;
    symIn = '0;
    repeat (3) @(negedge clk);
    chk(lvlVal(lineLevel) == 1, usePwr ? "R7 restart to +1" : "R6 restart to +1", lvlVal(lineLevel), 1);
    idle(6);
  endtask

  initial begin
    idle(3);
    tReset();
    tPatterns();
    tLatency();
    tStop(1'b0);
    tStop(1'b1);
    tPatterns();
    monOn = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", nChecks, nFails);
      $finish;
    end
  end

endmodule